// File: doc/BRIEF.md
# Sliding Window Moving Average

This block smooths one stream of signed samples by averaging the most recent N accepted samples. It produces one result for each accepted sample, so the output rate matches the input rate. A small ring of registers holds the window. A running total is updated on every sample by adding the newcomer and removing the sample that falls out of the window. The total is then scaled to a mean by multiplying with a stored reciprocal of N.

Each sample costs the same work whatever the window length, so the latency from input to output is fixed. The window length comes from a static input. When that input changes, the block empties the window, loads a new reciprocal and starts warming up again. No result leaves the block until the window holds N samples.

Top module: `mavg_window`

## Requirements
- R1: While reset is asserted and after it is released, out_valid is 0, out_data is 0, in_ready is 1 (with len_i equal to the default length of 5), and the active window length is 5.
- R2: Each result equals the sum of the last N accepted samples divided by N, truncated toward zero. Samples are 24-bit two's complement.
- R3: Once the window is full, every accepted sample (in_valid and in_ready both 1 at a clock edge) produces exactly one result. That result has out_valid = 1 two clock edges later, whatever N is.
- R4: After reset or a restart, the first N-1 accepted samples produce no result. The N-th and every later accepted sample produce a result.
- R5: A change of the requested length drives in_ready to 0 for exactly the one cycle in which the request differs from the active length. The sample offered in that cycle is not accepted. The window is emptied, so warm-up begins again at the new length.
- R6: A requested length of 0 acts as 1. A requested length above the maximum (127) acts as the maximum.
- R7: Cycles with in_valid = 0 leave the window unchanged and produce no result. Results after such a gap equal the results the same samples would give with no gap.
- R8: Results are exact at full scale with a 127-sample window. All samples at -2^23 give -2^23, and all samples at 2^23-1 give 2^23-1.
- R9: While out_valid is 0, out_data keeps the last value it presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| len_i | input | 7 | Requested window length (0 acts as 1) |
| in_valid | input | 1 | A sample is offered |
| in_ready | output | 1 | The block takes the offered sample at this edge |
| in_data | input | 24 | Signed input sample |
| out_valid | output | 1 | out_data carries a new mean |
| out_data | output | 24 | Signed mean of the window, truncated toward zero |

## Verification
The bench builds the block with its default parameters: 24-bit samples, a 127-sample maximum window and a start-up length of 5. At these settings the largest running total and the worst-case reciprocal error both occur. This lets full-scale windows of 127 samples test the claim that truncation is exact, alongside the degenerate length of 1 and the request of 0. Random lengths, mid-stream length changes and random gaps in in_valid drive the warm-up counting and the ring pointer wrap at many window sizes.

// File: rtl/mavg_window.sv
module mavg_window #(
  parameter int DW    = 24,
  parameter int MAXN  = 127,
  parameter int DEF_N = 5,
  localparam int LW   = $clog2(MAXN + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [LW-1:0]        len_i,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic signed [DW-1:0] in_data,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_data
);

  localparam int SW   = DW + LW;
  localparam int MW   = SW - 1;
  localparam int FRAC = MW + LW + 1;
  localparam int CW   = FRAC + 1;
  localparam int PW   = MW + CW;
  localparam logic [CW-1:0] ONE = CW'(1) << FRAC;
  localparam logic [CW-1:0] COEF0 = (ONE + CW'(DEF_N) - CW'(1)) / CW'(DEF_N);

  logic signed [DW-1:0] win [MAXN];
  logic [LW-1:0]        act_len, req_len, wp, fill;
  logic [CW-1:0]        coef_q, coef_nx;
  logic signed [SW-1:0] sum_q, sum_nx;
  logic signed [DW-1:0] oldest;
  logic                 chg, acc, warm, s1_v;
  logic                 neg;
  logic [MW-1:0]        mag;
  logic [PW-1:0]        prod;
  logic [DW-1:0]        quot;

  assign req_len = (len_i == '0) ? LW'(1) :
                   (len_i > LW'(MAXN)) ? LW'(MAXN) : len_i;
  assign chg      = req_len != act_len;
  assign in_ready = !chg;
  assign acc      = in_valid && in_ready;
  assign oldest   = (fill == act_len) ? win[wp] : '0;
  assign sum_nx   = sum_q + SW'(in_data) - SW'(oldest);
  assign warm     = fill >= act_len - LW'(1);
  assign coef_nx  = (ONE + CW'(req_len) - CW'(1)) / CW'(req_len);

  assign neg  = sum_q[SW-1];
  assign mag  = neg ? MW'(-sum_q) : MW'(sum_q);
  assign prod = PW'(mag) * PW'(coef_q);
  assign quot = prod[FRAC +: DW];

  always_ff @(posedge clk) begin
    if (acc) win[wp] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_len   <= LW'(DEF_N);
      coef_q    <= COEF0;
      sum_q     <= '0;
      wp        <= '0;
      fill      <= '0;
      s1_v      <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= s1_v;
      if (s1_v) out_data <= neg ? -$signed(quot) : $signed(quot);
      if (chg) begin
        act_len <= req_len;
        coef_q  <= coef_nx;
        sum_q   <= '0;
        wp      <= '0;
        fill    <= '0;
        s1_v    <= 1'b0;
      end else begin
        s1_v <= acc && warm;
        if (acc) begin
          sum_q <= sum_nx;
          wp    <= (wp == act_len - LW'(1)) ? '0 : wp + LW'(1);
          if (fill != act_len) fill <= fill + LW'(1);
        end
      end
    end
  end

endmodule

module mavg_window_chk #(
  parameter int DW    = 24,
  parameter int MAXN  = 127,
  parameter int DEF_N = 5,
  localparam int LW   = $clog2(MAXN + 1)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [LW-1:0]        len_i,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic signed [DW-1:0] in_data,
  input logic                 out_valid,
  input logic signed [DW-1:0] out_data
);

  logic [LW-1:0] want;
  logic [7:0]    cnt;
  logic          acc, full_now, v1, v2;

  assign want     = (len_i == '0) ? LW'(1) : (len_i > LW'(MAXN)) ? LW'(MAXN) : len_i;
  assign acc      = in_valid && in_ready;
  assign full_now = acc && ({1'b0, cnt} + 9'd1 >= 9'(want));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      v1  <= 1'b0;
      v2  <= 1'b0;
    end else begin
      v1 <= full_now;
      v2 <= v1;
      if (!in_ready) cnt <= '0;
      else if (acc && cnt != 8'hff) cnt <= cnt + 8'd1;
    end
  end

  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |-> (!out_valid && out_data == '0));

  // R3 R4
  warmup_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == v2);

  // R5
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> (in_ready || !$stable(len_i)));

  // R9
  hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_data));

endmodule

bind mavg_window mavg_window_chk #(.DW(DW), .MAXN(MAXN), .DEF_N(DEF_N)) chk_i (
  .clk(clk), .rst_n(rst_n), .len_i(len_i), .in_valid(in_valid),
  .in_ready(in_ready), .in_data(in_data), .out_valid(out_valid), .out_data(out_data)
);

// File: tb/mavg_window_tb_top.sv
module mavg_window_tb_top;
  localparam int DW = 24;
  localparam int MAXN = 127;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [6:0] len_i = 7'd5;
  logic in_valid = 1'b0;
  logic in_ready;
  logic signed [DW-1:0] in_data = '0;
  logic out_valid;
  logic signed [DW-1:0] out_data;

  always #5 clk = ~clk;

  mavg_window dut_i (
    .clk(clk), .rst_n(rst_n), .len_i(len_i), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_data(out_data)
  );

  int vectors = 0, fails = 0;
  bit done = 0;
  int hist[$];
  int nact = 5;
  bit ev1 = 0, ev2 = 0;
  int ed1 = 0, ed2 = 0, last_out = 0;
  string tag1 = "R2", tag2 = "R2";

  function automatic int clampn(int l);
    if (l == 0) return 1;
    if (l > MAXN) return MAXN;
    return l;
  endfunction

  function automatic int mean_of(int n);
    longint s = 0;
    for (int i = hist.size() - n; i < hist.size(); i++) s += hist[i];
    return int'(s / n);
  endfunction

  task automatic fail(string tag, int act, int exp);
    fails++;
    $display("FAIL %s: got %0d expected %0d", tag, act, exp);
  endtask

  task automatic step(bit v, int d, int l, string tag);
    bit rdy;
    int o;
    @(negedge clk);
    o = int'($signed(out_data));
    vectors++;
    if (out_valid !== ev2) fail("R3 R4 out_valid", int'(out_valid), int'(ev2));
    else if (ev2 && o != ed2) fail(tag2, o, ed2);
    else if (!ev2 && o != last_out) fail("R9 hold", o, last_out);
    if (out_valid === 1'b1) last_out = o;
    ev2 = ev1; ed2 = ed1; tag2 = tag1;
    len_i = 7'(l); in_valid = v; in_data = DW'(d);
    #1;
    rdy = (clampn(l) == nact);
    vectors++;
    if (in_ready !== rdy) fail("R5 in_ready", int'(in_ready), int'(rdy));
    if (!rdy) begin
      nact = clampn(l);
      hist.delete();
      ev1 = 0;
    end else if (v) begin
      hist.push_back(d);
      if (hist.size() > MAXN) void'(hist.pop_front());
      ev1 = hist.size() >= nact;
      if (ev1) ed1 = mean_of(nact);
      tag1 = tag;
    end else ev1 = 0;
  endtask

  function automatic int rnd24();
    return int'($signed(24'($urandom)));
  endfunction

  task automatic rand_run(int l, int n, int pct, string tag);
    for (int i = 0; i < n; i++) begin
      bit v = ($urandom_range(99) < pct);
      step(v, rnd24(), l, tag);
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    vectors++;
    if (out_valid !== 1'b0 || out_data !== '0 || in_ready !== 1'b1)
      fail("R1 reset state", int'({out_valid, in_ready}), 1);
    rst_n = 1'b1;
    // R4 R2 directed warm-up at default length 5
    for (int i = 1; i <= 8; i++) step(1, i * 10 - 45, 5, "R2 directed");
    // R2 R7 random with gaps
    rand_run(5, 200, 100, "R2 random");
    rand_run(5, 200, 60, "R7 gaps");
    // R6 length 1 then request 0
    rand_run(1, 30, 80, "R6 len1");
    rand_run(0, 30, 80, "R6 len0");
    // R5 mid-stream change to maximum, R8 full scale
    for (int i = 0; i < 140; i++) step(1, -(1 << 23), 127, "R8 negfs");
    for (int i = 0; i < 140; i++) step(1, (1 << 23) - 1, 127, "R8 posfs");
    // R5 random lengths with changes
    for (int k = 0; k < 6; k++) rand_run($urandom_range(2, 127), 200, 85, "R5 R2 relen");
    rand_run(3, 40, 50, "R5 R7 short");
    for (int i = 0; i < 4; i++) step(0, 0, 3, "R7 drain");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule